// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This controller watches a parameterised set of external input lines. Each line is first brought into the clock domain through two flops. An edge on a line, rising, falling or either one as software selects, is recorded in a per-line pending flag. Software reaches the controller over a small 32-bit register bus that has a single valid cycle. Through it, software sets the masks and trigger selects, raises lines by software, and acknowledges pending lines by writing ones to them.

Two outputs leave the block. A level interrupt request stays high while any pending line is also enabled in the interrupt mask. A separate one-cycle wake-up event pulse follows any selected edge on a line that is enabled in the event mask, and this path does not depend on the interrupt mask.

Register bits above the implemented line count cannot be written and always read zero. Software can therefore find the line count by writing all ones to a register and reading it back. The register decode is the only enumerated structure in the block. Its named selections are: interrupt mask, event mask, rising select, falling select, software trigger, pending, and none (any other offset). There are no state transitions beyond the per-line flags.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset every register reads 0 and both `irq_out` and `evt_out` are low.
- R2: The register byte offsets are: interrupt mask 0x00, event mask 0x04, rising select 0x08, falling select 0x0C, software trigger 0x10, pending 0x14. Bit n of each register belongs to line n. A read requested in cycle k shows its data on `bus_rdata` after edge k. `bus_rdata` holds that value until the next read.
- R3: A line whose rising-select bit is 1 latches a pending bit on a 0-to-1 transition. The transition is driven before edge j, and the pending bit and `irq_out` become visible after edge j+2.
- R4: A line whose falling-select bit is 1 latches on a 1-to-0 transition. With both select bits set the line latches on either edge. With neither bit set it never latches.
- R5: An edge sets a pending bit only when the line's interrupt-mask bit is 1 at that edge.
- R6: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged.
- R7: If an edge and a clearing write hit the same pending bit in the same cycle, the bit remains set.
- R8: `irq_out` is high exactly while some line has both its pending bit and its interrupt-mask bit set. Clearing the mask bit lowers `irq_out` and leaves the pending bit intact.
- R9: `evt_out` pulses high for one cycle after a selected edge, or a software trigger, on a line whose event-mask bit is 1. This happens whatever the line's interrupt-mask bit is.
- R10: Writing 1 to a software-trigger bit sets it. It also sets the pending bit, as an edge would (gated by the interrupt mask). The software-trigger bit clears itself when that pending bit is cleared.
- R11: Register bits at or above `NUM_LINES` ignore writes and read 0.
- R12: Writes to offsets outside the six registers change nothing, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| lines_async | input | NUM_LINES | External lines, asynchronous to clk |
| irq_out | output | 1 | Combined interrupt request |
| evt_out | output | 1 | One-cycle wake-up event pulse |

## Verification
The two synchroniser flops and the edge flop put every latched edge at the third clock edge after the line changes. The bench therefore expects `irq_out` to be low one cycle before that point and high right after it. `evt_out` is expected on the same edge. Read data and software-trigger effects are due one edge after the bus cycle. A behavioural model advances on each rising edge and is compared with all outputs at every falling edge. This covers the case where a clearing write is timed to land on the exact edge at which a new edge is latched.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

    localparam int OFF_IMASK = 'h00;
    localparam int OFF_EMASK = 'h04;
    localparam int OFF_RISE  = 'h08;
    localparam int OFF_FALL  = 'h0C;
    localparam int OFF_SWT   = 'h10;
    localparam int OFF_PEND  = 'h14;

    typedef enum logic [2:0] {
        SEL_IMASK,
        SEL_EMASK,
        SEL_RISE,
        SEL_FALL,
        SEL_SWT,
        SEL_PEND,
        SEL_NONE
    } reg_sel_e;

    function automatic reg_sel_e decode_sel(input logic [31:0] a);
        reg_sel_e s;
        case (a)
            OFF_IMASK: s = SEL_IMASK;
            OFF_EMASK: s = SEL_EMASK;
            OFF_RISE:  s = SEL_RISE;
            OFF_FALL:  s = SEL_FALL;
            OFF_SWT:   s = SEL_SWT;
            OFF_PEND:  s = SEL_PEND;
            default:   s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/eirq_edge_sync.sv
module eirq_edge_sync #(
    parameter int NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] lines_async,
    output logic [NUM_LINES-1:0] rise_o,
    output logic [NUM_LINES-1:0] fall_o
);

    logic [NUM_LINES-1:0] meta_q;
    logic [NUM_LINES-1:0] sync_q;
    logic [NUM_LINES-1:0] prev_q;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q[g] <= 1'b0;
                sync_q[g] <= 1'b0;
                prev_q[g] <= 1'b0;
            end else begin
                meta_q[g] <= lines_async[g];
                sync_q[g] <= meta_q[g];
                prev_q[g] <= sync_q[g];
            end
        end
        assign rise_o[g] =  sync_q[g] & ~prev_q[g];
        assign fall_o[g] = ~sync_q[g] &  prev_q[g];
    end

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0)); // R3

    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_o != '0) |=> ((fall_o & $past(fall_o)) == '0)); // R4

endmodule

// File: rtl/eirq_regs.sv
module eirq_regs
    import eirq_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int ADDR_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_valid,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_LINES-1:0] rise_i,
    input  logic [NUM_LINES-1:0] fall_i,
    output logic                 irq_o,
    output logic                 evt_o
);

    reg_sel_e             sel;
    logic                 wr_en;
    logic                 rd_en;
    logic [NUM_LINES-1:0] wdata_l;
    logic [NUM_LINES-1:0] imask_q, emask_q, rise_sel_q, fall_sel_q, swt_q, pend_q;
    logic [NUM_LINES-1:0] sw_set, pend_clr, trig, set_v;
    logic [31:0]          rd_val;
    logic [31:0]          rdata_q;
    logic                 evt_q;

    assign sel     = decode_sel(32'(bus_addr));
    assign wr_en   = bus_valid &  bus_wr;
    assign rd_en   = bus_valid & ~bus_wr;
    assign wdata_l = bus_wdata[NUM_LINES-1:0];

    if (NUM_LINES < 32) begin : g_spare
        logic unused_wdata_hi;
        assign unused_wdata_hi = ^bus_wdata[31:NUM_LINES];
    end

    always_comb begin
        sw_set   = (wr_en && sel == SEL_SWT)  ? wdata_l : '0;
        pend_clr = (wr_en && sel == SEL_PEND) ? wdata_l : '0;
        trig     = (rise_i & rise_sel_q) | (fall_i & fall_sel_q) | sw_set;
        set_v    = trig & imask_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            imask_q    <= '0;
            emask_q    <= '0;
            rise_sel_q <= '0;
            fall_sel_q <= '0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_IMASK: imask_q    <= wdata_l;
                SEL_EMASK: emask_q    <= wdata_l;
                SEL_RISE:  rise_sel_q <= wdata_l;
                SEL_FALL:  fall_sel_q <= wdata_l;
                SEL_SWT, SEL_PEND, SEL_NONE: ;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            swt_q  <= '0;
            evt_q  <= 1'b0;
        end else begin
            pend_q <= (pend_q & ~pend_clr) | set_v;
            swt_q  <= (swt_q | sw_set) & ~pend_clr;
            evt_q  <= |(trig & emask_q);
        end
    end

    always_comb begin
        unique case (sel)
            SEL_IMASK: rd_val = 32'(imask_q);
            SEL_EMASK: rd_val = 32'(emask_q);
            SEL_RISE:  rd_val = 32'(rise_sel_q);
            SEL_FALL:  rd_val = 32'(fall_sel_q);
            SEL_SWT:   rd_val = 32'(swt_q);
            SEL_PEND:  rd_val = 32'(pend_q);
            SEL_NONE:  rd_val = '0;
            default:   rd_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_val;
    end

    assign bus_rdata = rdata_q;
    assign irq_o     = |(pend_q & imask_q);
    assign evt_o     = evt_q;

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_clr != '0 && (pend_clr & set_v) == '0) |=> ((pend_q & $past(pend_clr)) == '0)); // R6

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_v != '0) |=> ((pend_q & $past(set_v)) == $past(set_v))); // R7

    AST_PEND_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & ~$past(pend_q) & ~$past(imask_q)) == '0)); // R5

    AST_EVT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |-> ($past(((rise_i & rise_sel_q) | (fall_i & fall_sel_q) | sw_set) & emask_q) != '0)); // R9

    AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(irq_o) && !$past(wr_en)) |-> irq_o); // R8

    if (NUM_LINES < 32) begin : g_hi_chk
        AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (rdata_q[31:NUM_LINES] == '0)); // R11
    end

endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl #(
    parameter int NUM_LINES = 8,
    parameter int ADDR_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_valid,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_LINES-1:0] lines_async,
    output logic                 irq_out,
    output logic                 evt_out
);

    logic [NUM_LINES-1:0] line_rise;
    logic [NUM_LINES-1:0] line_fall;

    eirq_edge_sync #(.NUM_LINES(NUM_LINES)) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .lines_async (lines_async),
        .rise_o      (line_rise),
        .fall_o      (line_fall)
    );

    eirq_regs #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rise_i    (line_rise),
        .fall_i    (line_fall),
        .irq_o     (irq_out),
        .evt_o     (evt_out)
    );

    AST_RST_QUIET: assert property (@(posedge clk)
        $past(!rst_n) |-> (!irq_out && !evt_out && bus_rdata == '0)); // R1

endmodule

// File: tb/test_edge_irq_ctrl.sv
module test_edge_irq_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NL = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        b_valid = 1'b0;
    logic        b_wr = 1'b0;
    logic [7:0]  b_addr = '0;
    logic [31:0] b_wdata = '0;
    logic [31:0] rdata;
    logic [NL-1:0] lines = '0;
    logic        irq, evt;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    edge_irq_ctrl #(.NUM_LINES(NL), .ADDR_W(8)) i_edge_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_valid(b_valid), .bus_wr(b_wr),
        .bus_addr(b_addr), .bus_wdata(b_wdata), .bus_rdata(rdata),
        .lines_async(lines), .irq_out(irq), .evt_out(evt)
    );

    // behavioural reference state
    logic [NL-1:0] m_im, m_em, m_rs, m_fs, m_sw, m_pd, m_s1, m_s2, m_p;
    logic          m_evt;
    logic [31:0]   m_rd;

    always @(posedge clk or negedge rst_n) begin
        logic [NL-1:0] hit, swset, clr, wd;
        logic [31:0] rv;
        if (!rst_n) begin
            m_im = '0; m_em = '0; m_rs = '0; m_fs = '0; m_sw = '0; m_pd = '0;
            m_s1 = '0; m_s2 = '0; m_p = '0; m_evt = 0; m_rd = '0;
        end else begin
            wd = b_wdata[NL-1:0];
            swset = (b_valid && b_wr && b_addr == 8'h10) ? wd : '0;
            clr   = (b_valid && b_wr && b_addr == 8'h14) ? wd : '0;
            hit = ((m_s2 & ~m_p) & m_rs) | ((~m_s2 & m_p) & m_fs) | swset;
            case (b_addr)
                8'h00: rv = 32'(m_im);
                8'h04: rv = 32'(m_em);
                8'h08: rv = 32'(m_rs);
                8'h0C: rv = 32'(m_fs);
                8'h10: rv = 32'(m_sw);
                8'h14: rv = 32'(m_pd);
                default: rv = 0;
            endcase
            if (b_valid && !b_wr) m_rd = rv;
            m_evt = (hit & m_em) != 0;
            m_pd = (m_pd & ~clr) | (hit & m_im);
            m_sw = (m_sw | swset) & ~clr;
            if (b_valid && b_wr) begin
                if (b_addr == 8'h00) m_im = wd;
                if (b_addr == 8'h04) m_em = wd;
                if (b_addr == 8'h08) m_rs = wd;
                if (b_addr == 8'h0C) m_fs = wd;
            end
            m_p = m_s2; m_s2 = m_s1; m_s1 = lines;
        end
    end

    task automatic expect_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            expect_eq("R8 irq_out vs model", {31'b0, irq}, {31'b0, (m_pd & m_im) != 0});
            expect_eq("R9 evt_out vs model", {31'b0, evt}, {31'b0, m_evt});
            expect_eq("R2 bus_rdata vs model", rdata, m_rd);
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); b_valid = 1; b_wr = 1; b_addr = a; b_wdata = d;
        @(negedge clk); b_valid = 0; b_wr = 0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); b_valid = 1; b_wr = 0; b_addr = a;
        @(negedge clk); b_valid = 0;
        expect_eq(tag, rdata, exp);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        int ecount;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset values
        expect_eq("R1 irq after reset", {31'b0, irq}, 32'h0);
        rd_chk(8'h00, 0, "R1 imask reset");
        rd_chk(8'h04, 0, "R1 emask reset");
        rd_chk(8'h08, 0, "R1 rise reset");
        rd_chk(8'h0C, 0, "R1 fall reset");
        rd_chk(8'h10, 0, "R1 swt reset");
        rd_chk(8'h14, 0, "R1 pend reset");
        // R11: upper bits
        wr(8'h08, 32'hFFFF_FFFF);
        rd_chk(8'h08, 32'h0000_00FF, "R11 rise width");
        wr(8'h00, 32'hFFFF_FFFF);
        rd_chk(8'h00, 32'h0000_00FF, "R11 imask width");
        // R12: unmapped
        wr(8'h18, 32'hFFFF_FFFF);
        rd_chk(8'h18, 0, "R12 unmapped read");
        rd_chk(8'h00, 32'h0000_00FF, "R12 unmapped write no effect");
        // configuration
        wr(8'h00, 32'h0F);
        wr(8'h04, 32'h30);
        wr(8'h08, 32'h35);
        wr(8'h0C, 32'h06);
        rd_chk(8'h04, 32'h30, "R2 emask offset");
        rd_chk(8'h0C, 32'h06, "R2 fall offset");
        // R3: rising latency
        @(negedge clk); lines[0] = 1;
        @(negedge clk);
        @(negedge clk);
        expect_eq("R3 irq not yet", {31'b0, irq}, 0);
        @(negedge clk);
        expect_eq("R3 irq at third edge", {31'b0, irq}, 1);
        rd_chk(8'h14, 32'h01, "R3 pend rising");
        // R6
        wr(8'h14, 32'h0);
        rd_chk(8'h14, 32'h01, "R6 write zero keeps");
        wr(8'h14, 32'h01);
        rd_chk(8'h14, 32'h00, "R6 write one clears");
        expect_eq("R6 irq low after clear", {31'b0, irq}, 0);
        // R4: falling only on line1, both on line2, none on line3
        @(negedge clk); lines[1] = 1; settle();
        rd_chk(8'h14, 32'h00, "R4 rise ignored on fall line");
        @(negedge clk); lines[1] = 0; settle();
        rd_chk(8'h14, 32'h02, "R4 fall latched");
        @(negedge clk); lines[2] = 1; settle();
        rd_chk(8'h14, 32'h06, "R4 both rise");
        wr(8'h14, 32'h06);
        @(negedge clk); lines[2] = 0; settle();
        rd_chk(8'h14, 32'h04, "R4 both fall");
        wr(8'h14, 32'h04);
        @(negedge clk); lines[3] = 1; settle();
        @(negedge clk); lines[3] = 0; settle();
        rd_chk(8'h14, 32'h00, "R4 no select never latches");
        // R5 + R9: line4 event only
        @(negedge clk); lines[4] = 1;
        ecount = 0;
        repeat (6) begin
            @(negedge clk);
            if (evt) ecount++;
        end
        expect_eq("R9 single event pulse", ecount, 1);
        expect_eq("R5 masked line no irq", {31'b0, irq}, 0);
        rd_chk(8'h14, 32'h00, "R5 masked line not pending");
        // R8: masking lowers irq, keeps pending
        @(negedge clk); lines[0] = 0; settle();
        @(negedge clk); lines[0] = 1; settle();
        expect_eq("R8 irq high", {31'b0, irq}, 1);
        wr(8'h00, 32'h0E);
        expect_eq("R8 irq masked", {31'b0, irq}, 0);
        rd_chk(8'h14, 32'h01, "R8 pending kept under mask");
        wr(8'h00, 32'h0F);
        expect_eq("R8 irq back", {31'b0, irq}, 1);
        wr(8'h14, 32'h01);
        // R10: software trigger
        wr(8'h10, 32'h08);
        expect_eq("R10 irq from sw", {31'b0, irq}, 1);
        rd_chk(8'h14, 32'h08, "R10 pend from sw");
        rd_chk(8'h10, 32'h08, "R10 swt bit set");
        wr(8'h14, 32'h08);
        rd_chk(8'h10, 32'h00, "R10 swt self clear");
        // R9: software trigger on event line
        wr(8'h10, 32'h20);
        rd_chk(8'h14, 32'h00, "R9 sw event line not pending");
        wr(8'h14, 32'h20);
        // R7: clear collides with new edge on line2
        @(negedge clk); lines[2] = 1; settle();
        @(negedge clk); lines[2] = 0;
        @(negedge clk);
        @(negedge clk); b_valid = 1; b_wr = 1; b_addr = 8'h14; b_wdata = 32'h04;
        @(negedge clk); b_valid = 0; b_wr = 0;
        rd_chk(8'h14, 32'h04, "R7 set wins over clear");
        wr(8'h14, 32'h04);
        rd_chk(8'h14, 32'h00, "R7 later clear works");
        settle();
        finish_up();
    end

endmodule